// File: doc/BRIEF.md
# Reorder Buffer with In-Entry Result Storage

This block keeps instructions that are in flight in program order between the rename stage and the architectural register file. Each cycle the rename stage may claim a group of `LANES` consecutive slots. Every slot it claims is returned as an index. Execution units later report completion through a set of write-back ports addressed by that index. Each report carries the result value and an exception flag. The result is held inside the slot itself. It reaches the register file only when the slot commits.

Commit runs from the oldest slot. Up to `LANES` slots may commit in one cycle, and each one drives a register-file write port with its destination and value. The committing group ends at the first slot that has not finished. A slot that finished with an exception commits nothing. When such a slot becomes the oldest, the block raises a one-cycle flush and empties itself. Committed slots are freed at the same clock edge, so the space is available for allocation in the next cycle.

Top module: `result_rob`

## Requirements
- R1: After reset, `alloc_ready` is 1, `flush` is 0, every `ret_we` bit is 0, and the first allocated group gets slot indices 0 to LANES-1.
- R2: An allocation happens when `alloc_valid` and `alloc_ready` are both high. It claims LANES slots whose indices are `alloc_idx[i] = (tail + i) mod DEPTH`, with lane 0 the oldest. `tail` then advances by LANES.
- R3: `alloc_ready` is 0 when fewer than LANES slots are free, counted at the start of the cycle, or when `flush` is high. An `alloc_valid` without `alloc_ready` claims nothing, so allocation is all-or-nothing.
- R4: A write-back on port c (`cpl_valid[c]`) marks the slot at `cpl_idx[c]` complete and stores `cpl_data[c]` and `cpl_exc[c]` in it. The change is visible from the next cycle. A write-back to a slot that is not in flight has no effect.
- R5: Commit lane i asserts `ret_we[i]` in the same cycle that the slot at `(head + i) mod DEPTH` is eligible to commit. In that cycle it drives that slot's destination on `ret_dst[i]` and its stored value on `ret_data[i]`. The slot is freed at that clock edge.
- R6: Commit lanes form a prefix from the head. Lane i commits only if every older lane commits. A completed slot behind an unfinished one waits.
- R7: A slot completed with an exception is never written out. Commit of a group stops just before it. When it is the oldest slot, `flush` is 1 for that cycle, with no `ret_we`. At the clock edge all slots are discarded and head, tail and occupancy return to 0.
- R8: In a flush cycle, allocation requests and write-backs have no effect. The next allocated group starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Rename stage offers a group of LANES instructions |
| alloc_dst | input | LANES×REG_W | Destination register of each lane, lane 0 oldest |
| alloc_ready | output | 1 | A full group can be accepted this cycle |
| alloc_idx | output | LANES×IDX_W | Slot index that each lane receives |
| cpl_valid | input | CPL_PORTS | Write-back strobe per port |
| cpl_idx | input | CPL_PORTS×IDX_W | Slot addressed by each write-back port |
| cpl_data | input | CPL_PORTS×DATA_W | Result value per write-back port |
| cpl_exc | input | CPL_PORTS | Exception flag per write-back port |
| ret_we | output | LANES | Register-file write enable per commit lane |
| ret_dst | output | LANES×REG_W | Destination register per commit lane |
| ret_data | output | LANES×DATA_W | Committed value per commit lane |
| flush | output | 1 | Oldest slot faulted; the buffer empties at this edge |

## Verification
The embedded properties check five things on every cycle. Occupancy never exceeds the depth. Head, tail and occupancy stay consistent around the ring. Allocation only ever claims free slots. An accepted write-back leaves its slot marked complete. A flush leaves all three pointers at zero. Other behaviour depends on the order of completions and exceptions, so only the bench's scenarios can show it. That covers which lanes commit, which values they carry, that a faulting slot stalls a group, that space frees in time, and that requests arriving during a flush are dropped. The bench runs these scenarios against a queue-based model.

// File: rtl/rob_pkg.sv
package rob_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE  = 2'd0,
      SLOT_BUSY  = 2'd1,
      SLOT_READY = 2'd2,
      SLOT_FAULT = 2'd3
   } slot_e;

   function automatic slot_e slot_of(input logic live, input logic done, input logic exc);
      if (!live)     return SLOT_FREE;
      else if (!done) return SLOT_BUSY;
      else if (exc)   return SLOT_FAULT;
      else            return SLOT_READY;
   endfunction

endpackage

// File: rtl/rob_store.sv
module rob_store #(
   parameter int DEPTH     = 16,
   parameter int LANES     = 2,
   parameter int CPL_PORTS = 2,
   parameter int DATA_W    = 32,
   parameter int REG_W     = 5,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                flush,
   input  logic [IDX_W-1:0]                    head,
   input  logic [IDX_W-1:0]                    tail,
   input  logic                                alloc_fire,
   input  logic [LANES-1:0][REG_W-1:0]         alloc_dst,
   input  logic [CPL_PORTS-1:0]                cpl_valid,
   input  logic [CPL_PORTS-1:0][IDX_W-1:0]     cpl_idx,
   input  logic [CPL_PORTS-1:0][DATA_W-1:0]    cpl_data,
   input  logic [CPL_PORTS-1:0]                cpl_exc,
   input  logic [LANES-1:0]                    ret_mask,
   output rob_pkg::slot_e [LANES-1:0]          win_state,
   output logic [LANES-1:0][REG_W-1:0]         win_dst,
   output logic [LANES-1:0][DATA_W-1:0]        win_data
);

   logic [DEPTH-1:0]   live_q, done_q, exc_q;
   logic [REG_W-1:0]   dst_q [DEPTH];
   logic [DATA_W-1:0]  val_q [DEPTH];
   logic [IDX_W-1:0]   rd_idx [LANES];
   logic [IDX_W-1:0]   wr_idx [LANES];

   for (genvar i = 0; i < LANES; i++) begin : g_lane_idx
      assign rd_idx[i] = head + IDX_W'(i);
      assign wr_idx[i] = tail + IDX_W'(i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q <= '0;
         done_q <= '0;
         exc_q  <= '0;
      end else if (flush) begin
         live_q <= '0;
      end else begin
         for (int i = 0; i < LANES; i++)
            if (ret_mask[i]) live_q[rd_idx[i]] <= 1'b0;
         for (int c = 0; c < CPL_PORTS; c++)
            if (cpl_valid[c] && live_q[cpl_idx[c]]) begin
               done_q[cpl_idx[c]] <= 1'b1;
               exc_q[cpl_idx[c]]  <= cpl_exc[c];
            end
         if (alloc_fire)
            for (int i = 0; i < LANES; i++) begin
               live_q[wr_idx[i]] <= 1'b1;
               done_q[wr_idx[i]] <= 1'b0;
               exc_q[wr_idx[i]]  <= 1'b0;
            end
      end
   end

   always_ff @(posedge clk) begin
      if (rst_n && !flush) begin
         for (int c = 0; c < CPL_PORTS; c++)
            if (cpl_valid[c] && live_q[cpl_idx[c]]) val_q[cpl_idx[c]] <= cpl_data[c];
         if (alloc_fire)
            for (int i = 0; i < LANES; i++) dst_q[wr_idx[i]] <= alloc_dst[i];
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_window
      assign win_state[i] = rob_pkg::slot_of(live_q[rd_idx[i]], done_q[rd_idx[i]], exc_q[rd_idx[i]]);
      assign win_dst[i]   = dst_q[rd_idx[i]];
      assign win_data[i]  = val_q[rd_idx[i]];

      // R2: a claimed slot must have been free
      assert_alloc_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
         alloc_fire |-> !live_q[wr_idx[i]]);
   end

   for (genvar c = 0; c < CPL_PORTS; c++) begin : g_cpl_chk
      // R4: an accepted write-back leaves its slot complete
      assert_cpl_marks_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (cpl_valid[c] && live_q[cpl_idx[c]] && !flush) |=> done_q[$past(cpl_idx[c])]);
   end

endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
   parameter int LANES = 2
) (
   input  rob_pkg::slot_e [LANES-1:0] win_state,
   output logic [LANES-1:0]           ret_mask,
   output logic                       flush
);

   logic [LANES:0] go;
   assign go[0] = 1'b1;

   for (genvar i = 0; i < LANES; i++) begin : g_chain
      assign go[i+1]     = go[i] && (win_state[i] == rob_pkg::SLOT_READY);
      assign ret_mask[i] = go[i+1];
   end

   assign flush = (win_state[0] == rob_pkg::SLOT_FAULT);

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl #(
   parameter int DEPTH = 16,
   parameter int LANES = 2,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc_valid,
   input  logic [LANES-1:0] ret_mask,
   input  logic             flush,
   output logic             alloc_ready,
   output logic             alloc_fire,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail
);

   logic [IDX_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] count_q, ret_cnt;

   always_comb begin
      ret_cnt = '0;
      for (int i = 0; i < LANES; i++) ret_cnt = ret_cnt + CNT_W'(ret_mask[i]);
   end

   assign alloc_ready = !flush && ((CNT_W'(DEPTH) - count_q) >= CNT_W'(LANES));
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign head        = head_q;
   assign tail        = tail_q;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         head_q  <= head_q + IDX_W'(ret_cnt);
         tail_q  <= tail_q + (alloc_fire ? IDX_W'(LANES) : '0);
         count_q <= count_q - ret_cnt + (alloc_fire ? CNT_W'(LANES) : '0);
      end
   end

   // R3: occupancy never exceeds the depth
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CNT_W'(DEPTH));

   // R2: ring distance between pointers matches occupancy
   assert_ring_span_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_q - head_q) == count_q[IDX_W-1:0]);

   // R7: a flush leaves the ring empty and rewound
   assert_flush_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0 && head_q == '0 && tail_q == '0));

endmodule

// File: rtl/result_rob.sv
module result_rob #(
   parameter int DEPTH     = 16,
   parameter int LANES     = 2,
   parameter int CPL_PORTS = 2,
   parameter int DATA_W    = 32,
   parameter int REG_W     = 5,
   localparam int IDX_W    = $clog2(DEPTH)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              alloc_valid,
   input  logic [LANES-1:0][REG_W-1:0]       alloc_dst,
   output logic                              alloc_ready,
   output logic [LANES-1:0][IDX_W-1:0]       alloc_idx,
   input  logic [CPL_PORTS-1:0]              cpl_valid,
   input  logic [CPL_PORTS-1:0][IDX_W-1:0]   cpl_idx,
   input  logic [CPL_PORTS-1:0][DATA_W-1:0]  cpl_data,
   input  logic [CPL_PORTS-1:0]              cpl_exc,
   output logic [LANES-1:0]                  ret_we,
   output logic [LANES-1:0][REG_W-1:0]       ret_dst,
   output logic [LANES-1:0][DATA_W-1:0]      ret_data,
   output logic                              flush
);

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $fatal(1, "DEPTH must be a power of two");
      assert (LANES >= 1 && LANES <= DEPTH) else $fatal(1, "LANES out of range");
      assert (CPL_PORTS >= 1) else $fatal(1, "CPL_PORTS must be positive");
      assert (DATA_W >= 1 && REG_W >= 1) else $fatal(1, "widths must be positive");
   end

   logic [IDX_W-1:0]            head, tail;
   logic                        alloc_fire;
   logic [LANES-1:0]            ret_mask;
   logic                        flush_w;
   rob_pkg::slot_e [LANES-1:0]  win_state;

   rob_ctrl #(.DEPTH(DEPTH), .LANES(LANES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .ret_mask(ret_mask),
      .flush(flush_w), .alloc_ready(alloc_ready), .alloc_fire(alloc_fire),
      .head(head), .tail(tail));

   rob_store #(.DEPTH(DEPTH), .LANES(LANES), .CPL_PORTS(CPL_PORTS),
               .DATA_W(DATA_W), .REG_W(REG_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush_w), .head(head), .tail(tail),
      .alloc_fire(alloc_fire), .alloc_dst(alloc_dst), .cpl_valid(cpl_valid),
      .cpl_idx(cpl_idx), .cpl_data(cpl_data), .cpl_exc(cpl_exc),
      .ret_mask(ret_mask), .win_state(win_state), .win_dst(ret_dst),
      .win_data(ret_data));

   rob_pick #(.LANES(LANES)) u_pick (
      .win_state(win_state), .ret_mask(ret_mask), .flush(flush_w));

   for (genvar i = 0; i < LANES; i++) begin : g_idx_out
      assign alloc_idx[i] = tail + IDX_W'(i);
   end

   assign ret_we = ret_mask;
   assign flush  = flush_w;

endmodule

// File: tb/result_rob_tb.sv
module result_rob_tb;
   localparam int CLK_NS = 10;
   localparam int DEPTH = 8, W = 2, C = 2, DW = 32, RW = 5, IW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic                     a_valid;
   logic [W-1:0][RW-1:0]     a_dst;
   logic                     a_ready;
   logic [W-1:0][IW-1:0]     a_idx;
   logic [C-1:0]             c_valid, c_exc;
   logic [C-1:0][IW-1:0]     c_idx;
   logic [C-1:0][DW-1:0]     c_data;
   logic [W-1:0]             r_we;
   logic [W-1:0][RW-1:0]     r_dst;
   logic [W-1:0][DW-1:0]     r_data;
   logic                     fl;

   always #(CLK_NS/2) clk = ~clk;

   result_rob #(.DEPTH(DEPTH), .LANES(W), .CPL_PORTS(C), .DATA_W(DW), .REG_W(RW)) u_dut (
      .clk(clk), .rst_n(rst_n), .alloc_valid(a_valid), .alloc_dst(a_dst),
      .alloc_ready(a_ready), .alloc_idx(a_idx), .cpl_valid(c_valid), .cpl_idx(c_idx),
      .cpl_data(c_data), .cpl_exc(c_exc), .ret_we(r_we), .ret_dst(r_dst),
      .ret_data(r_data), .flush(fl));

   typedef struct { int idx; int dst; logic [DW-1:0] val; bit done; bit exc; } ent_t;
   ent_t q[$];
   int tail_m = 0;
   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit prev_flush = 0, finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int p_alloc, input int p_cpl, input int p_exc);
      bit e_flush, e_ready, chain;
      bit [W-1:0] e_we;
      int pend[$];
      int nret;
      @(negedge clk);
      a_valid = ($urandom % 100) < p_alloc;
      for (int i = 0; i < W; i++) a_dst[i] = RW'($urandom);
      for (int c = 0; c < C; c++) begin
         c_valid[c] = 1'b0; c_exc[c] = 1'b0; c_data[c] = $urandom; c_idx[c] = '0;
         if (($urandom % 100) < p_cpl) begin
            int idx;
            pend.delete();
            foreach (q[k]) if (!q[k].done) pend.push_back(k);
            if (pend.size() > 0 && ($urandom % 8) != 0) idx = q[pend[$urandom % pend.size()]].idx;
            else idx = $urandom % DEPTH;
            if (!(c > 0 && c_valid[0] && int'(c_idx[0]) == idx)) begin
               c_valid[c] = 1'b1;
               c_idx[c]   = IW'(idx);
               c_exc[c]   = ($urandom % 100) < p_exc;
            end
         end
      end
      #1;
      e_flush = q.size() > 0 && q[0].done && q[0].exc;
      e_ready = (DEPTH - q.size() >= W) && !e_flush;
      chain = 1; nret = 0;
      for (int i = 0; i < W; i++) begin
         chain = chain && i < q.size() && q[i].done && !q[i].exc;
         e_we[i] = chain;
         if (chain) nret++;
      end
      chk(fl == e_flush, "R7", "flush", fl, e_flush);
      chk(a_ready == e_ready, "R3", "alloc_ready", a_ready, e_ready);
      for (int i = 0; i < W; i++) begin
         int ei = (tail_m + i) % DEPTH;
         chk(int'(a_idx[i]) == ei, prev_flush ? "R8" : "R2", "alloc_idx", a_idx[i], ei);
         chk(r_we[i] == e_we[i], (i == 0) ? "R5" : "R6", "ret_we", r_we[i], e_we[i]);
         if (e_we[i]) begin
            chk(int'(r_dst[i]) == q[i].dst, "R5", "ret_dst", r_dst[i], q[i].dst);
            chk(r_data[i] == q[i].val, "R4", "ret_data", r_data[i], q[i].val);
         end
      end
      // reference update at the coming edge
      prev_flush = e_flush;
      if (e_flush) begin
         q.delete();
         tail_m = 0;
      end else begin
         for (int c = 0; c < C; c++)
            if (c_valid[c])
               foreach (q[k])
                  if (q[k].idx == int'(c_idx[c])) begin
                     q[k].done = 1; q[k].exc = c_exc[c]; q[k].val = c_data[c];
                  end
         for (int i = 0; i < nret; i++) void'(q.pop_front());
         if (a_valid && e_ready) begin
            for (int i = 0; i < W; i++) begin
               ent_t e;
               e.idx = (tail_m + i) % DEPTH; e.dst = int'(a_dst[i]);
               e.val = '0; e.done = 0; e.exc = 0;
               q.push_back(e);
            end
            tail_m = (tail_m + W) % DEPTH;
         end
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 200000 && !finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      a_valid = 0; a_dst = '0; c_valid = '0; c_exc = '0; c_idx = '0; c_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(a_ready == 1'b1, "R1", "alloc_ready after reset", a_ready, 1);
      chk(fl == 1'b0, "R1", "flush after reset", fl, 0);
      chk(r_we == '0, "R1", "ret_we after reset", r_we, 0);
      chk(a_idx[0] == '0, "R1", "first index", a_idx[0], 0);
      repeat (8)    step(100, 0, 0);    // fill to full, ready must drop (R3)
      repeat (12)   step(0, 100, 0);    // out-of-order completion drains (R4, R5, R6)
      repeat (2000) step(60, 70, 5);    // mixed traffic
      repeat (600)  step(70, 80, 30);   // exception-heavy, flush cycles (R7, R8)
      repeat (300)  step(90, 40, 0);    // mostly full ring
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule